// File: doc/BRIEF.md
# Four-Pin General-Purpose I/O Port with Change Interrupts

This block gives a host four general-purpose pins behind a byte-wide synchronous register bus. Each pin can be set as an input or an output. A pin set as an output is driven from a stored output bit. The level of every pin passes through a two-stage synchronizer and can be read back whatever the pin's direction.

A level change on an unmasked input pin sets a sticky per-pin flag in a status register. The host clears a flag by writing a 1 to its bit. An active-low interrupt line stays low while any flag is set.

Register reads are combinational from the address. Writes take effect on the next rising clock edge when the write enable is high.

Top module: `quad_pin_port`

## Requirements
- R1: After reset the direction register (address 05h, bit i = 1 means pin i is an input) reads 0Fh and the mask register (06h, bit i = 1 means masked) reads 0Fh. The output register (09h) and the status register (08h) read 00h, pinOe is 0000 and irqN is 1.
- R2: Bits 3:0 of the input register (07h) show the pin levels after a two-flop synchronizer. A pin change is visible on a read after the second rising edge, not after the first, and this holds for inputs and outputs alike.
- R3: A write to 07h changes no register: direction, mask, output and status all read the same before and after it.
- R4: The output register (09h) stores bits 3:0 of a write and reads back the stored value, not the level on the pins.
- R5: For each pin i, pinOe[i] = 1 exactly when direction bit i is 0. pinOut[i] equals output bit i for output pins and is 0 for input pins.
- R6: A level change on a pin whose direction bit is 1 and whose mask bit is 0 sets status bit i (08h) on the third rising edge after the pin changes. The bit stays set while the pin stays stable.
- R7: A change on a masked pin, or on a pin set as an output, sets no status bit.
- R8: Writing 08h clears each status bit written as 1 and leaves bits written as 0 alone. When a new change for a bit arrives in the same cycle as its clear, the bit stays set.
- R9: irqN is 0 exactly when at least one status bit is set.
- R10: Bits 7:4 of the direction, mask, input, output and status registers read as 0. Reads of any other address return 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | 8 | Register address |
| busWe | input | 1 | Write enable for the current cycle |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data for busAddr, combinational |
| pinIn | input | 4 | Level seen on each pin |
| pinOut | output | 4 | Output level per pin |
| pinOe | output | 4 | Output enable per pin, 1 = drive |
| irqN | output | 1 | Interrupt, low while any flag is set |

## Verification
The assertions assume that busAddr, busWe and busWdata are settled and free of X at each rising edge. They also assume that pinIn may change at any time, because the synchronizer absorbs the asynchrony.

The bench changes every bus signal and every pin level at the falling edge, half a period away from the capturing edge. It models the pad so that an output pin reads back its driven level and an input pin reads back the externally forced level. This keeps the stimulus inside those assumptions. The same-cycle clear-and-set case is arranged by counting the synchronizer stages from the falling edge of the pin change.

// File: rtl/qpp_pkg.sv
package qpp_pkg;

  typedef enum logic [2:0] {
    RD_NONE = 3'd0,
    RD_DIR  = 3'd1,
    RD_MASK = 3'd2,
    RD_IN   = 3'd3,
    RD_STAT = 3'd4,
    RD_OUT  = 3'd5
  } rdSel_e;

  typedef struct packed {
    logic   wrDir;
    logic   wrMask;
    logic   wrOut;
    logic   wrClr;
    rdSel_e rdSel;
  } strobe_t;

endpackage

// File: rtl/qpp_ctrl.sv
module qpp_ctrl
  import qpp_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DIR_ADDR  = 5,
  parameter int MASK_ADDR = 6,
  parameter int IN_ADDR   = 7,
  parameter int STAT_ADDR = 8,
  parameter int OUT_ADDR  = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  output strobe_t           strobes
);

  localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(DIR_ADDR);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(MASK_ADDR);
  localparam logic [ADDR_W-1:0] A_IN   = ADDR_W'(IN_ADDR);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_ADDR);
  localparam logic [ADDR_W-1:0] A_OUT  = ADDR_W'(OUT_ADDR);

  always_comb begin
    strobes        = '0;
    strobes.rdSel  = RD_NONE;
    unique case (busAddr)
      A_DIR: begin
        strobes.rdSel = RD_DIR;
        strobes.wrDir = busWe;
      end
      A_MASK: begin
        strobes.rdSel  = RD_MASK;
        strobes.wrMask = busWe;
      end
      A_IN: begin
        strobes.rdSel = RD_IN;
      end
      A_STAT: begin
        strobes.rdSel = RD_STAT;
        strobes.wrClr = busWe;
      end
      A_OUT: begin
        strobes.rdSel = RD_OUT;
        strobes.wrOut = busWe;
      end
      default: strobes.rdSel = RD_NONE;
    endcase
  end

  // R3: a write aimed at the input register raises no write strobe
  a_r3_in_write_inert: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == A_IN) |-> !(strobes.wrDir || strobes.wrMask || strobes.wrOut || strobes.wrClr));

  a_r10_unmapped_no_strobe: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.rdSel == RD_NONE) |-> !(strobes.wrDir || strobes.wrMask || strobes.wrOut || strobes.wrClr));

endmodule

// File: rtl/qpp_datapath.sv
module qpp_datapath
  import qpp_pkg::*;
#(
  parameter int NUM_PINS    = 4,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             strobes,
  input  logic [DATA_W-1:0]   busWdata,
  output logic [DATA_W-1:0]   busRdata,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic [NUM_PINS-1:0] pinOut,
  output logic [NUM_PINS-1:0] pinOe,
  output logic                irqN
);

  localparam int PAD_W = DATA_W - NUM_PINS;

  logic [NUM_PINS-1:0] dirReg;
  logic [NUM_PINS-1:0] maskReg;
  logic [NUM_PINS-1:0] outReg;
  logic [NUM_PINS-1:0] flagReg;
  logic [NUM_PINS-1:0] prevIn;
  logic [NUM_PINS-1:0] syncChain [SYNC_STAGES];
  logic [NUM_PINS-1:0] syncIn;
  logic [NUM_PINS-1:0] pinChange;
  logic [NUM_PINS-1:0] clrBits;
  logic [NUM_PINS-1:0] wrBits;

  assign wrBits = busWdata[NUM_PINS-1:0];

  // synchronizer chain, depth chosen by parameter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncChain[0] <= '0;
    else       syncChain[0] <= pinIn;
  end

  generate
    for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncChain[s] <= '0;
        else       syncChain[s] <= syncChain[s-1];
      end
    end
  endgenerate

  assign syncIn = syncChain[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevIn <= '0;
    else       prevIn <= syncIn;
  end

  assign pinChange = (syncIn ^ prevIn) & dirReg & ~maskReg;
  assign clrBits   = strobes.wrClr ? wrBits : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirReg  <= '1;
      maskReg <= '1;
      outReg  <= '0;
      flagReg <= '0;
    end else begin
      if (strobes.wrDir)  dirReg  <= wrBits;
      if (strobes.wrMask) maskReg <= wrBits;
      if (strobes.wrOut)  outReg  <= wrBits;
      flagReg <= (flagReg & ~clrBits) | pinChange;
    end
  end

  assign pinOe  = ~dirReg;
  assign pinOut = outReg & ~dirReg;
  assign irqN   = ~(|flagReg);

  always_comb begin
    unique case (strobes.rdSel)
      RD_DIR:  busRdata = {{PAD_W{1'b0}}, dirReg};
      RD_MASK: busRdata = {{PAD_W{1'b0}}, maskReg};
      RD_IN:   busRdata = {{PAD_W{1'b0}}, syncIn};
      RD_STAT: busRdata = {{PAD_W{1'b0}}, flagReg};
      RD_OUT:  busRdata = {{PAD_W{1'b0}}, outReg};
      default: busRdata = '0;
    endcase
  end

  generate
    for (genvar i = 0; i < NUM_PINS; i++) begin : g_chk
      // R6/R7: a flag can only rise for an unmasked input pin
      a_r7_flag_source: assert property (@(posedge clk) disable iff (!rstN)
        $rose(flagReg[i]) |-> $past(dirReg[i] && !maskReg[i]));
      // R8: a clear with no coincident change empties the flag
      a_r8_clear: assert property (@(posedge clk) disable iff (!rstN)
        (strobes.wrClr && wrBits[i] && !pinChange[i]) |=> !flagReg[i]);
      // R8: a coincident change wins over the clear
      a_r8_set_wins: assert property (@(posedge clk) disable iff (!rstN)
        pinChange[i] |=> flagReg[i]);
      // R6: without a clear the flag is sticky
      a_r6_sticky: assert property (@(posedge clk) disable iff (!rstN)
        (flagReg[i] && !(strobes.wrClr && wrBits[i])) |=> flagReg[i]);
    end
  endgenerate

  // R4: the output register only moves on its own write
  a_r4_out_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.wrOut |=> $stable(outReg));

  // R5: a direction write sets the enables one cycle later
  a_r5_dir_to_oe: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrDir |=> (pinOe == ~$past(wrBits)));

  // R9: interrupt line low while a flag is set
  a_r9_irq: assert property (@(posedge clk) disable iff (!rstN)
    ($countones(flagReg) != 0) |-> !irqN);

  // R10: reserved upper bits read zero
  a_r10_reserved: assert property (@(posedge clk) disable iff (!rstN)
    busRdata[DATA_W-1:NUM_PINS] == '0);

endmodule

// File: rtl/quad_pin_port.sv
module quad_pin_port
  import qpp_pkg::*;
#(
  parameter int NUM_PINS    = 4,
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic                busWe,
  input  logic [DATA_W-1:0]   busWdata,
  output logic [DATA_W-1:0]   busRdata,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic [NUM_PINS-1:0] pinOut,
  output logic [NUM_PINS-1:0] pinOe,
  output logic                irqN
);

  strobe_t strobes;

  qpp_ctrl #(
    .ADDR_W(ADDR_W)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .busAddr (busAddr),
    .busWe   (busWe),
    .strobes (strobes)
  );

  qpp_datapath #(
    .NUM_PINS    (NUM_PINS),
    .DATA_W      (DATA_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .pinIn    (pinIn),
    .pinOut   (pinOut),
    .pinOe    (pinOe),
    .irqN     (irqN)
  );

endmodule

// File: tb/quad_pin_port_bench.sv
module quad_pin_port_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] busAddr = 8'h00;
  logic       busWe = 1'b0;
  logic [7:0] busWdata = 8'h00;
  logic [7:0] busRdata;
  logic [3:0] pinIn;
  logic [3:0] pinOut;
  logic [3:0] pinOe;
  logic       irqN;
  logic [3:0] extDrv = 4'b0101;

  int testCount = 0;
  int failCount = 0;

  always #2 clk = ~clk;

  // pad model: output pins read back their driven level
  always_comb
    for (int i = 0; i < 4; i++) pinIn[i] = pinOe[i] ? pinOut[i] : extDrv[i];

  quad_pin_port u_quad_pin_port (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .pinIn(pinIn),
    .pinOut(pinOut), .pinOe(pinOe), .irqN(irqN)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0; busWdata = 8'h00;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    busAddr = a; busWe = 1'b0;
    #1 d = busRdata;
  endtask

  task automatic rdChk(input string req, input logic [7:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failCount++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    logic [7:0] v;
    cyc(3);
    rstN = 1'b1;
    cyc(1);
    // R1 reset state
    rdChk("R1 dir", 8'h05, 8'h0F);
    rdChk("R1 mask", 8'h06, 8'h0F);
    rdChk("R1 out", 8'h09, 8'h00);
    rdChk("R1 stat", 8'h08, 8'h00);
    check("R1 oe", {4'h0, pinOe}, 8'h00);
    check("R1 irq", {7'h0, irqN}, 8'h01);

    // R2 synchronizer depth
    cyc(3);
    rdChk("R2 settled", 8'h07, 8'h05);
    extDrv = 4'b1010;
    cyc(1);
    rdChk("R2 one edge", 8'h07, 8'h05);
    cyc(1);
    rdChk("R2 two edges", 8'h07, 8'h0A);

    // R3 write to input register is inert
    wr(8'h07, 8'hFF);
    rdChk("R3 dir", 8'h05, 8'h0F);
    rdChk("R3 mask", 8'h06, 8'h0F);
    rdChk("R3 out", 8'h09, 8'h00);
    rdChk("R3 stat", 8'h08, 8'h00);
    rdChk("R3 in", 8'h07, 8'h0A);

    // R4 output register stores the flip-flop value, pins still inputs
    wr(8'h09, 8'hC5);
    rdChk("R4 out", 8'h09, 8'h05);
    rdChk("R4 pins differ", 8'h07, 8'h0A);
    check("R5 inputs undriven", {4'h0, pinOut}, 8'h00);

    // R5 direction
    wr(8'h05, 8'h03);
    check("R5 oe", {4'h0, pinOe}, 8'h0C);
    check("R5 out", {4'h0, pinOut}, 8'h04);

    // R10 reserved and unmapped
    wr(8'h06, 8'hFF);
    rdChk("R10 mask reserved", 8'h06, 8'h0F);
    rdChk("R10 addr 00", 8'h00, 8'h00);
    rdChk("R10 addr 0A", 8'h0A, 8'h00);
    rdChk("R10 addr 04", 8'h04, 8'h00);

    // R6 R7 R9 exhaustive sweep over direction and mask
    for (int d = 0; d < 16; d++) begin
      for (int m = 0; m < 16; m++) begin
        logic [3:0] dirV, mskV, outV, expIn;
        dirV = 4'(d); mskV = 4'(m); outV = 4'(d ^ m);
        wr(8'h06, 8'h0F);
        wr(8'h05, {4'h0, dirV});
        wr(8'h09, {4'h0, outV});
        cyc(4);
        wr(8'h08, 8'h0F);
        wr(8'h06, {4'h0, mskV});
        extDrv = ~extDrv;
        cyc(4);
        expIn = (extDrv & dirV) | (outV & ~dirV);
        rdChk("R2 sweep in", 8'h07, {4'h0, expIn});
        rdChk("R6 R7 sweep flags", 8'h08, {4'h0, dirV & ~mskV});
        check("R9 sweep irq", {7'h0, irqN}, {7'h0, ((dirV & ~mskV) == 4'h0)});
        cyc(2);
        rdChk("R6 sticky", 8'h08, {4'h0, dirV & ~mskV});
      end
    end

    // R8 clear behaviour
    wr(8'h06, 8'h0F);
    wr(8'h05, 8'h0F);
    cyc(4);
    wr(8'h08, 8'h0F);
    wr(8'h06, 8'h00);
    extDrv[0] = ~extDrv[0];
    cyc(4);
    rdChk("R8 flag set", 8'h08, 8'h01);
    wr(8'h08, 8'h0E);
    rdChk("R8 zero bits keep", 8'h08, 8'h01);
    wr(8'h08, 8'h01);
    rdChk("R8 cleared", 8'h08, 8'h00);
    check("R9 irq released", {7'h0, irqN}, 8'h01);

    // R8 set wins: flag 1 set, change lands in the clear cycle
    extDrv[1] = ~extDrv[1];
    cyc(4);
    rdChk("R8 pre", 8'h08, 8'h02);
    extDrv[1] = ~extDrv[1];
    cyc(2);
    wr(8'h08, 8'h02);
    rdChk("R8 set wins", 8'h08, 8'h02);
    check("R9 irq held", {7'h0, irqN}, 8'h00);

    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

endmodule